// File: doc/BRIEF.md
# Pseudo-Static RAM Power-Up and Access Controller

This controller sits between a simple request/response host port and a one-mebiword, 16-bit pseudo-static RAM that has an SRAM-style pin set. The pins are chip select, a standby-mode select, output enable, write enable and two byte-lane enables. After reset it holds the memory idle for a long settling interval. It then issues a fixed number of dummy reads. Each dummy read is framed by its own chip-select pulse, and output enable and the data bus stay quiet throughout. Only after these reads does it report ready to the host.

Once ready, the controller serves word and single-byte reads and writes. Every access lasts a parameterized number of clock cycles, and chip select is returned high for a recovery gap after each one. The host may also hold a deep-sleep request. This parks the memory in its data-losing standby state. When the request is dropped, the complete power-up sequence runs again before ready returns. All lengths are counted in clock ticks. For example, at 50 MHz the settling interval is 10000 cycles, and a 5-cycle access covers an 85 ns access time.

Top module: `psram_ctrl`

## Requirements
- R1: After reset, and again after leaving deep sleep, mem_cs_n and mem_mode stay high and host_ready stays low for at least WAIT_CYC cycles before chip select first falls.
- R2: The settling interval is followed by exactly INIT_READS dummy reads. In each one mem_cs_n falls and is low for RD_CYC cycles, while mem_oe_n and mem_we_n stay high and mem_dq_oe stays low.
- R3: host_ready is high only when the controller is idle with mem_cs_n and mem_mode high, and never before all dummy reads have completed. A request is taken on a cycle where host_valid and host_ready are both high.
- R4: A read (host_write=0) drives mem_cs_n low, mem_oe_n low and mem_we_n high for RD_CYC cycles. host_be bit 0 selects lane bits 7:0 through mem_lb_n=0, and bit 1 selects bits 15:8 through mem_ub_n=0. The captured word appears on host_rdata with a one-cycle host_rvalid pulse.
- R5: In host_rdata, a lane that was not enabled reads as zero.
- R6: A write (host_write=1) drives mem_cs_n low, mem_we_n low and mem_oe_n high for WR_CYC cycles, with host_wdata on mem_dq_out. Only the enabled lanes are stored.
- R7: A write with host_be=00 keeps both lane enables high, so nothing is stored.
- R8: mem_dq_oe is high only while mem_cs_n and mem_we_n are low and mem_oe_n is high, so the bus is released before any read enables outputs.
- R9: After every access, mem_cs_n stays high for at least GAP_CYC cycles before the next fall.
- R10: With host_dsleep high while idle and no request valid, the controller drives mem_mode low with mem_cs_n high and drops host_ready. A request valid in the same cycle is served first.
- R11: mem_mode is low only together with mem_cs_n high. When host_dsleep falls, the full R1 and R2 sequence reruns, and the previous memory contents are treated as lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Request valid |
| host_write | input | 1 | 1 = write, 0 = read |
| host_be | input | 2 | Lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| host_addr | input | 20 | Word address |
| host_wdata | input | 16 | Write data |
| host_dsleep | input | 1 | Deep-sleep request level |
| host_ready | output | 1 | Idle and able to accept a request |
| host_rdata | output | 16 | Read data, disabled lanes zero |
| host_rvalid | output | 1 | One-cycle read data strobe |
| mem_addr | output | 20 | Memory address |
| mem_dq_out | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_mode | output | 1 | Standby mode select, low = data-losing standby |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |

## Verification
The hardest situation to reach is the return from deep sleep. The host must first store data and then hold the sleep request. The stimulus must also check that a request raised in the same cycle as the sleep request is still served. Only then does the memory lose its contents and the second full power-up run start. The stimulus writes known words, raises a read and the sleep request together, and confirms the read completes before the mode pin falls. It then releases the request and checks that ready comes back only after the full wait and dummy reads. A read of the earlier address must then return the blank pattern rather than the stored word. A behavioural memory flags any access that arrives before the dummy reads, too early, or with output enable low.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_WAIT  = 3'd0,
    ST_IREAD = 3'd1,
    ST_IGAP  = 3'd2,
    ST_IDLE  = 3'd3,
    ST_READ  = 3'd4,
    ST_WRITE = 3'd5,
    ST_GAP   = 3'd6,
    ST_DEEP  = 3'd7
  } st_e;

  typedef struct packed {
    logic cs_n;
    logic mode;
    logic oe_n;
    logic we_n;
    logic lb_n;
    logic ub_n;
    logic dq_oe;
  } pins_t;

  localparam pins_t PINS_QUIET = '{cs_n: 1'b1, mode: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                   lb_n: 1'b1, ub_n: 1'b1, dq_oe: 1'b0};

  function automatic pins_t pin_decode(st_e st, logic [1:0] be);
    pins_t p;
    p = PINS_QUIET;
    unique case (st)
      ST_IREAD: begin
        p.cs_n = 1'b0;
        p.lb_n = 1'b0;
        p.ub_n = 1'b0;
      end
      ST_READ: begin
        p.cs_n = 1'b0;
        p.oe_n = 1'b0;
        p.lb_n = ~be[0];
        p.ub_n = ~be[1];
      end
      ST_WRITE: begin
        p.cs_n  = 1'b0;
        p.we_n  = 1'b0;
        p.lb_n  = ~be[0];
        p.ub_n  = ~be[1];
        p.dq_oe = 1'b1;
      end
      ST_DEEP: p.mode = 1'b0;
      default: p = PINS_QUIET;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/psram_tick_timer.sv
module psram_tick_timer #(
  parameter int CNT_W     = 14,
  parameter int RESET_VAL = 9999
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= CNT_W'(RESET_VAL);
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/psram_seq.sv
module psram_seq
  import psram_ctrl_pkg::*;
#(
  parameter int CNT_W      = 14,
  parameter int WAIT_CYC   = 10000,
  parameter int INIT_READS = 3,
  parameter int RD_CYC     = 5,
  parameter int WR_CYC     = 5,
  parameter int GAP_CYC    = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_valid,
  input  logic             host_write,
  input  logic             host_dsleep,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output st_e              nstate,
  output logic             accept,
  output logic             capture,
  output logic             ready
);
  localparam int LEFT_W = $clog2(INIT_READS + 1);

  st_e              state_q;
  logic [LEFT_W-1:0] left_q, left_n;

  always_comb begin
    nstate   = state_q;
    left_n   = left_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_WAIT: if (tmr_zero) begin
        nstate   = ST_IREAD;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(RD_CYC - 1);
      end
      ST_IREAD: if (tmr_zero) begin
        nstate   = ST_IGAP;
        left_n   = left_q - 1'b1;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(GAP_CYC - 1);
      end
      ST_IGAP: if (tmr_zero) begin
        if (left_q == '0) begin
          nstate = ST_IDLE;
        end else begin
          nstate   = ST_IREAD;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(RD_CYC - 1);
        end
      end
      ST_IDLE: begin
        if (host_valid) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          if (host_write) begin
            nstate  = ST_WRITE;
            tmr_val = CNT_W'(WR_CYC - 1);
          end else begin
            nstate  = ST_READ;
            tmr_val = CNT_W'(RD_CYC - 1);
          end
        end else if (host_dsleep) begin
          nstate = ST_DEEP;
        end
      end
      ST_READ: if (tmr_zero) begin
        capture  = 1'b1;
        nstate   = ST_GAP;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(GAP_CYC - 1);
      end
      ST_WRITE: if (tmr_zero) begin
        nstate   = ST_GAP;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(GAP_CYC - 1);
      end
      ST_GAP: if (tmr_zero) nstate = ST_IDLE;
      ST_DEEP: if (!host_dsleep) begin
        nstate   = ST_WAIT;
        left_n   = LEFT_W'(INIT_READS);
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WAIT_CYC - 1);
      end
      default: nstate = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_WAIT;
      left_q  <= LEFT_W'(INIT_READS);
      ready   <= 1'b0;
    end else begin
      state_q <= nstate;
      left_q  <= left_n;
      ready   <= (nstate == ST_IDLE);
    end
  end
endmodule

// File: rtl/psram_pin_reg.sv
module psram_pin_reg
  import psram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  st_e               nstate,
  input  logic              accept,
  input  logic [1:0]        host_be,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              mem_cs_n,
  output logic              mem_mode,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n
);
  pins_t      pins_q;
  logic [1:0] be_q;
  logic [1:0] be_sel;

  assign be_sel = accept ? host_be : be_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q     <= PINS_QUIET;
      be_q       <= '0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else begin
      pins_q <= pin_decode(nstate, be_sel);
      if (accept) begin
        be_q       <= host_be;
        mem_addr   <= host_addr;
        mem_dq_out <= host_wdata;
      end
    end
  end

  assign mem_cs_n  = pins_q.cs_n;
  assign mem_mode  = pins_q.mode;
  assign mem_oe_n  = pins_q.oe_n;
  assign mem_we_n  = pins_q.we_n;
  assign mem_lb_n  = pins_q.lb_n;
  assign mem_ub_n  = pins_q.ub_n;
  assign mem_dq_oe = pins_q.dq_oe;
endmodule

// File: rtl/psram_rd_capture.sv
module psram_rd_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [1:0]        lane_en,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid
);
  localparam int LANE_W = DATA_W / 2;

  always_ff @(posedge clk) begin
    if (rst) host_rvalid <= 1'b0;
    else     host_rvalid <= capture;
  end

  for (genvar l = 0; l < 2; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)          host_rdata[l*LANE_W +: LANE_W] <= '0;
      else if (capture) host_rdata[l*LANE_W +: LANE_W] <=
                          lane_en[l] ? mem_dq_in[l*LANE_W +: LANE_W] : '0;
    end
  end
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int WAIT_CYC   = 10000,
  parameter int INIT_READS = 3,
  parameter int RD_CYC     = 5,
  parameter int WR_CYC     = 5,
  parameter int GAP_CYC    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [1:0]        host_be,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_dsleep,
  output logic              host_ready,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_cs_n,
  output logic              mem_mode,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n
);
  localparam int MAX_A = (WAIT_CYC > RD_CYC) ? WAIT_CYC : RD_CYC;
  localparam int MAX_B = (WR_CYC > GAP_CYC) ? WR_CYC : GAP_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_C + 1);

  logic             tmr_load, tmr_zero, accept, capture;
  logic [CNT_W-1:0] tmr_val;
  st_e              nstate;

  psram_tick_timer #(.CNT_W(CNT_W), .RESET_VAL(WAIT_CYC - 1)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  psram_seq #(
    .CNT_W(CNT_W), .WAIT_CYC(WAIT_CYC), .INIT_READS(INIT_READS),
    .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .GAP_CYC(GAP_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .host_valid(host_valid), .host_write(host_write),
    .host_dsleep(host_dsleep), .tmr_zero(tmr_zero), .tmr_load(tmr_load),
    .tmr_val(tmr_val), .nstate(nstate), .accept(accept), .capture(capture),
    .ready(host_ready)
  );

  psram_pin_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst(rst), .nstate(nstate), .accept(accept), .host_be(host_be),
    .host_addr(host_addr), .host_wdata(host_wdata), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_cs_n(mem_cs_n),
    .mem_mode(mem_mode), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n)
  );

  psram_rd_capture #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .capture(capture), .lane_en(~{mem_ub_n, mem_lb_n}),
    .mem_dq_in(mem_dq_in), .host_rdata(host_rdata), .host_rvalid(host_rvalid)
  );
endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
  parameter int WAIT_CYC   = 10000,
  parameter int INIT_READS = 3
) (
  input logic clk,
  input logic rst,
  input logic host_ready,
  input logic host_rvalid,
  input logic mem_dq_oe,
  input logic mem_cs_n,
  input logic mem_mode,
  input logic mem_oe_n,
  input logic mem_we_n
);
  localparam int WC_W = $clog2(WAIT_CYC + 2);
  localparam int FL_W = $clog2(INIT_READS + 1);

  logic            cs_d, armed;
  logic [WC_W-1:0] wcnt;
  logic [FL_W-1:0] falls;

  always_ff @(posedge clk) begin
    cs_d <= mem_cs_n;
    if (rst || !mem_mode) begin
      armed <= 1'b1;
      wcnt  <= '0;
      falls <= '0;
    end else begin
      if (armed && mem_cs_n && wcnt != WC_W'(WAIT_CYC + 1)) wcnt <= wcnt + 1'b1;
      if (cs_d && !mem_cs_n) begin
        armed <= 1'b0;
        if (falls != FL_W'(INIT_READS)) falls <= falls + 1'b1;
      end
    end
  end

  p_wait_before_toggle_r1: assert property (@(posedge clk) disable iff (rst)
    (armed && cs_d && !mem_cs_n) |-> (wcnt >= WC_W'(WAIT_CYC)));

  p_init_reads_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (cs_d && !mem_cs_n && falls < FL_W'(INIT_READS)) |-> (mem_oe_n && mem_we_n && !mem_dq_oe));

  p_ready_after_init_r3: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> (falls == FL_W'(INIT_READS) && mem_cs_n && mem_mode));

  p_rvalid_after_read_r4: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |-> $past(!mem_cs_n && !mem_oe_n));

  p_rvalid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |=> !host_rvalid);

  p_bus_release_r8: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (mem_oe_n && !mem_we_n && !mem_cs_n));

  p_deep_cs_high_r11: assert property (@(posedge clk) disable iff (rst)
    !mem_mode |-> mem_cs_n);
endmodule

bind psram_ctrl psram_ctrl_chk #(.WAIT_CYC(WAIT_CYC), .INIT_READS(INIT_READS)) u_chk (
  .clk(clk), .rst(rst), .host_ready(host_ready), .host_rvalid(host_rvalid),
  .mem_dq_oe(mem_dq_oe), .mem_cs_n(mem_cs_n), .mem_mode(mem_mode),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
);

// File: tb/psram_model.sv
module psram_model #(
  parameter int WAIT_CYC   = 300,
  parameter int INIT_READS = 3
) (
  input  logic        clk,
  input  logic        cs_n,
  input  logic        mode,
  input  logic        oe_n,
  input  logic        we_n,
  input  logic        lb_n,
  input  logic        ub_n,
  input  logic [19:0] addr,
  input  logic [15:0] dq_out,
  input  logic        dq_oe,
  output logic [15:0] dq_in,
  output int          viol,
  output int          clash
);
  logic [15:0] store [bit [19:0]];
  int   wait_cnt = 0;
  int   falls    = 0;
  bit   in_init  = 1'b1;
  logic cs_d     = 1'b1;

  function automatic logic [15:0] blank(logic [19:0] a);
    return {a[7:0] ^ 8'h3C, a[15:8] ^ 8'hC3};
  endfunction

  initial begin
    viol  = 0;
    clash = 0;
    dq_in = '0;
  end

  always @(posedge clk) begin
    if (mode !== 1'b1) begin
      store.delete();
      wait_cnt = 0;
      falls    = 0;
      in_init  = 1'b1;
    end else begin
      if (cs_n && falls == 0) wait_cnt = wait_cnt + 1;
      if (cs_d && !cs_n) begin
        if (falls < INIT_READS) begin
          if (wait_cnt < WAIT_CYC || !oe_n || !we_n) viol = viol + 1;
          falls   = falls + 1;
          in_init = 1'b1;
        end else begin
          in_init = 1'b0;
        end
      end
      if (!cs_n && !we_n && !in_init && dq_oe) begin
        logic [15:0] w;
        w = store.exists(addr) ? store[addr] : blank(addr);
        if (!lb_n) w[7:0]  = dq_out[7:0];
        if (!ub_n) w[15:8] = dq_out[15:8];
        if (!lb_n || !ub_n) store[addr] = w;
      end
      if (!cs_n && !we_n && in_init) viol = viol + 1;
    end
    if (dq_oe && !oe_n) clash = clash + 1;
    cs_d = cs_n;
  end

  always @(negedge clk) begin
    if (!cs_n && !oe_n && we_n && mode) begin
      logic [15:0] r;
      r = store.exists(addr) ? store[addr] : blank(addr);
      dq_in <= {ub_n ? 8'hEE : r[15:8], lb_n ? 8'hEE : r[7:0]};
    end
  end
endmodule

// File: tb/psram_ctrl_test.sv
module psram_ctrl_test;
  localparam int WAIT_CYC = 300;
  localparam int INIT_RD  = 3;
  localparam int RD_CYC   = 5;
  localparam int WR_CYC   = 4;
  localparam int GAP_CYC  = 2;
  localparam int INIT_LEN = WAIT_CYC + INIT_RD * (RD_CYC + GAP_CYC);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_valid = 1'b0, host_write = 1'b0, host_dsleep = 1'b0;
  logic [1:0]  host_be = 2'b00;
  logic [19:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic        host_ready, host_rvalid, mem_dq_oe;
  logic [15:0] host_rdata, mem_dq_out, mem_dq_in;
  logic [19:0] mem_addr;
  logic mem_cs_n, mem_mode, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
  int   viol, clash;
  int   tests = 0, fails = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  psram_ctrl #(.WAIT_CYC(WAIT_CYC), .INIT_READS(INIT_RD), .RD_CYC(RD_CYC),
               .WR_CYC(WR_CYC), .GAP_CYC(GAP_CYC)) uut (
    .clk(clk), .rst(rst), .host_valid(host_valid), .host_write(host_write),
    .host_be(host_be), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_dsleep(host_dsleep), .host_ready(host_ready), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_cs_n(mem_cs_n),
    .mem_mode(mem_mode), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n)
  );

  psram_model #(.WAIT_CYC(WAIT_CYC), .INIT_READS(INIT_RD)) u_mem (
    .clk(clk), .cs_n(mem_cs_n), .mode(mem_mode), .oe_n(mem_oe_n), .we_n(mem_we_n),
    .lb_n(mem_lb_n), .ub_n(mem_ub_n), .addr(mem_addr), .dq_out(mem_dq_out),
    .dq_oe(mem_dq_oe), .dq_in(mem_dq_in), .viol(viol), .clash(clash)
  );

  // pin monitors: gap after access (R9), ready only when quiet (R3), mode low only with cs high (R11)
  int gap_err = 0, rdy_err = 0, mode_err = 0, hi_run = 0, cs_falls = 0;
  logic cs_prev = 1'b1;
  always @(negedge clk) begin
    if (!rst) begin
      if (cs_prev && !mem_cs_n) begin
        cs_falls = cs_falls + 1;
        if (hi_run < GAP_CYC) gap_err = gap_err + 1;
        hi_run = 0;
      end
      if (mem_cs_n) hi_run = hi_run + 1;
      if (host_ready && (!mem_cs_n || !mem_mode)) rdy_err = rdy_err + 1;
      if (!mem_mode && !mem_cs_n) mode_err = mode_err + 1;
      cs_prev = mem_cs_n;
    end
  end

  logic [15:0] ref_mem [bit [19:0]];

  function automatic logic [15:0] blank(logic [19:0] a);
    return {a[7:0] ^ 8'h3C, a[15:8] ^ 8'hC3};
  endfunction

  function automatic logic [15:0] ref_word(logic [19:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : blank(a);
  endfunction

  function automatic logic [15:0] lane_mask(logic [15:0] w, logic [1:0] be);
    return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
  endfunction

  task automatic ref_write(logic [19:0] a, logic [1:0] be, logic [15:0] d);
    logic [15:0] w;
    w = ref_word(a);
    if (be[0]) w[7:0]  = d[7:0];
    if (be[1]) w[15:8] = d[15:8];
    if (be != 2'b00) ref_mem[a] = w;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests = tests + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(bit wr, logic [1:0] be, logic [19:0] a, logic [15:0] wd,
                    output logic [15:0] rd);
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_valid = 1'b1; host_write = wr; host_be = be; host_addr = a; host_wdata = wd;
    @(negedge clk);
    host_valid = 1'b0;
    rd = '0;
    if (!wr) begin
      while (!host_rvalid) @(negedge clk);
      rd = host_rdata;
    end
  endtask

  task automatic wr_op(logic [1:0] be, logic [19:0] a, logic [15:0] d);
    logic [15:0] dummy;
    op(1'b1, be, a, d, dummy);
    ref_write(a, be, d);
  endtask

  task automatic rd_chk(string req, logic [1:0] be, logic [19:0] a);
    logic [15:0] got;
    op(1'b0, be, a, 16'h0, got);
    chk(req, {16'h0, got}, {16'h0, lane_mask(ref_word(a), be)});
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!host_ready) begin
      @(negedge clk);
      n = n + 1;
    end
  endtask

  initial begin
    automatic int n;
    automatic logic [19:0] pool [8];
    automatic int seed_dummy;
    seed_dummy = $urandom(32'd1357);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 cs_n after reset", {31'h0, mem_cs_n}, 32'h1);
    chk("R1 mode after reset", {31'h0, mem_mode}, 32'h1);
    chk("R1 ready after reset", {31'h0, host_ready}, 32'h0);
    wait_ready(n);
    // R1/R2: full wait plus dummy reads before ready (R3)
    chk("R3 ready not before init", {31'h0, (n + 1 >= INIT_LEN)}, 32'h1);
    chk("R2 dummy read count", cs_falls, INIT_RD);
    chk("R1 R2 init order seen by memory", viol, 0);

    // directed: word, lane writes, abort, lane-masked reads
    wr_op(2'b11, 20'h00010, 16'hBEEF);
    rd_chk("R4 word read", 2'b11, 20'h00010);
    wr_op(2'b01, 20'h00010, 16'h1234);
    rd_chk("R6 lower lane write", 2'b11, 20'h00010);
    wr_op(2'b10, 20'h00010, 16'h5678);
    rd_chk("R6 upper lane write", 2'b11, 20'h00010);
    wr_op(2'b00, 20'h00010, 16'hFFFF);
    rd_chk("R7 write abort keeps word", 2'b11, 20'h00010);
    rd_chk("R5 lower only read upper zero", 2'b01, 20'h00010);
    rd_chk("R5 upper only read lower zero", 2'b10, 20'h00010);
    rd_chk("R5 no lanes read zero", 2'b00, 20'h00010);
    wr_op(2'b11, 20'hFFFFF, 16'hA55A);
    rd_chk("R4 top address", 2'b11, 20'hFFFFF);

    // random mix over a small address pool
    foreach (pool[i]) pool[i] = 20'($urandom);
    for (int k = 0; k < 60; k++) begin
      logic [19:0] a;
      logic [1:0]  be;
      a  = pool[$urandom % 8];
      be = 2'($urandom);
      if ($urandom % 2) wr_op(be, a, 16'($urandom));
      else rd_chk("R4 R6 random access", be, a);
    end

    // R10: read raised together with sleep request is served first
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_valid = 1'b1; host_write = 1'b0; host_be = 2'b11; host_addr = 20'h00010;
    host_dsleep = 1'b1;
    @(negedge clk);
    host_valid = 1'b0;
    while (!host_rvalid) @(negedge clk);
    chk("R10 request served before sleep", {16'h0, host_rdata}, {16'h0, ref_word(20'h00010)});
    repeat (GAP_CYC + 3) @(negedge clk);
    chk("R10 mode low in deep sleep", {31'h0, mem_mode}, 32'h0);
    chk("R10 cs high in deep sleep", {31'h0, mem_cs_n}, 32'h1);
    chk("R10 ready low in deep sleep", {31'h0, host_ready}, 32'h0);
    repeat (20) @(negedge clk);
    ref_mem.delete();
    cs_falls = 0;
    host_dsleep = 1'b0;
    wait_ready(n);
    chk("R11 full wait after deep sleep", {31'h0, (n + 1 >= INIT_LEN)}, 32'h1);
    chk("R11 dummy reads after deep sleep", cs_falls, INIT_RD);
    rd_chk("R11 contents lost after deep sleep", 2'b11, 20'h00010);
    wr_op(2'b11, 20'h00020, 16'hC0DE);
    rd_chk("R11 normal access after rerun", 2'b11, 20'h00020);

    chk("R1 R2 memory order violations", viol, 0);
    chk("R8 bus driven while output enabled", clash, 0);
    chk("R9 cs recovery gap", gap_err, 0);
    chk("R3 ready only when quiet", rdy_err, 0);
    chk("R11 mode low with cs low", mode_err, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests = tests + 1;
      fails = fails + 1;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule